// File: doc/BRIEF.md
# Windowed Watchdog Timer

This block is a watchdog for a processor subsystem. It runs from the peripheral clock. A programmable prescaler turns that clock into counter ticks, and each tick decrements a 14-bit down-counter. Software must service the watchdog with a two-step refresh sequence. The refresh has to land while the counter sits inside a permitted window. That window is bounded above by a start threshold and below by an end threshold, and each is chosen as a fraction of the full count. A refresh that comes too early or too late is reported as an error. Letting the counter run out is reported as an underflow. Either event raises a one-cycle pulse on `errOut`, which a reset or interrupt controller outside this block consumes.

A 16-bit configuration word holds four fields: the prescale ratio, the timeout length, the window start and the window end. After reset this word accepts one write. It freezes after that write, or as soon as the counter has been started. When the auto-start input is high, the word is taken from a configuration input instead of the register. The block's register port is a plain synchronous write port plus a combinational read port:

| Address | Write effect | Read value |
|---|---|---|
| 0 | configuration word | effective configuration |
| 1 | refresh bytes, in bits 7:0 | status |
| 2 | none | counter value |
| 3 | none | zero |

Top module: `wdog_window`

## Requirements
- R1: After reset, address 0 reads 0x33F3 and the status at address 1 reads 0. The counter at address 2 reads 0 and is stopped, and `errOut` is low.
- R2: Bits 15:14, 11:10 and 3:2 of the configuration word always read as zero, whatever value was written to them.
- R3: The divider field sits in bits 7:4. Its legal codes are 0001 (divide by 4), 0100 (64), 1111 (128), 0110 (512), 0111 (2048) and 1000 (8192). A configuration write that carries any other divider code is dropped entirely and does not use up the single permitted write.
- R4: The period field sits in bits 1:0 and selects the load value: 00 gives 1023, 01 gives 4095, 10 gives 8191 and 11 gives 16383. From the clock edge that accepts a refresh to the edge that reports underflow, the delay is exactly the divide ratio times (load value + 1) clock cycles.
- R5: Only the first legal configuration write after reset takes effect. Every later write is ignored. Every write is also ignored once the counter has been started, even if no configuration write came first.
- R6: A refresh is a write of 0x00 to address 1, then a write of 0xFF to address 1 with no other address-1 write in between. A 0xFF write without that preceding 0x00 is not a refresh. The first refresh starts a stopped counter at the load value, and no window check applies to it.
- R7: While the counter is running, a refresh is accepted and reloads the counter only when two conditions hold. The counter must be at or below the start threshold. The counter must also be above the end threshold, unless the end field is 11. The start field (bits 13:12) selects a start threshold of N/4-1, N/2-1, 3N/4-1 or N-1 for codes 00, 01, 10 and 11, where N is the load value + 1. The end field (bits 9:8) selects an end threshold of 3N/4-1, N/2-1 or N/4-1 for codes 00, 01 and 10, and code 11 sets no end limit.
- R8: A refresh rejected by the window sets status bit 1 and drives `errOut` high for one cycle. The counter keeps counting down without being reloaded.
- R9: When a tick arrives with the counter at 0, status bit 0 is set and `errOut` is high for exactly one cycle. The counter then stays stopped at 0, and status bit 2 (running) stays low until the next refresh restarts the count from the load value.
- R10: While `autoStart` is high, the effective configuration is `autoCfg` with its reserved bits cleared. This value is what address 0 reads back, and it sets the timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe, one write per cycle |
| wrAddr | input | 2 | Write address |
| wrData | input | 16 | Write data |
| rdAddr | input | 2 | Read address |
| rdData | output | 16 | Combinational read data |
| autoStart | input | 1 | Selects `autoCfg` as the configuration |
| autoCfg | input | 16 | Alternate configuration word |
| errOut | output | 1 | One-cycle error pulse for underflow or a rejected refresh |

## Verification
The assertions assume that `autoStart` and `autoCfg` stay constant from reset onward. They also assume that `autoCfg` always carries one of the six legal divider codes, because no write filter guards that path. The stimulus sets both inputs only while reset is held and uses only legal divider codes in auto mode. It exercises illegal divider codes only through register writes, where R3 requires them to be dropped.

// File: rtl/wdw_pkg.sv
package wdw_pkg;

  localparam int WORD_W = 16;
  localparam int CNT_W  = 14;
  localparam int PRE_W  = 13;

  localparam logic [WORD_W-1:0] CFG_RESET = 16'h33F3;
  localparam logic [WORD_W-1:0] CFG_MASK  = 16'h33F3;

  typedef struct packed {
    logic [1:0] startSel;
    logic [1:0] endSel;
    logic [3:0] divSel;
    logic [1:0] perSel;
  } cfg_t;

  typedef struct packed {
    logic loadCnt;
    logic armSeq;
  } strobe_t;

  function automatic cfg_t toCfg(input logic [WORD_W-1:0] w);
    cfg_t c;
    c.startSel = w[13:12];
    c.endSel   = w[9:8];
    c.divSel   = w[7:4];
    c.perSel   = w[1:0];
    return c;
  endfunction

  function automatic logic legalDiv(input logic [3:0] code);
    case (code)
      4'b0001, 4'b0100, 4'b1111, 4'b0110, 4'b0111, 4'b1000: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // last prescaler state before a tick (ratio - 1)
  function automatic logic [PRE_W-1:0] divLast(input logic [3:0] code);
    case (code)
      4'b0001: return PRE_W'(3);
      4'b0100: return PRE_W'(63);
      4'b1111: return PRE_W'(127);
      4'b0110: return PRE_W'(511);
      4'b0111: return PRE_W'(2047);
      4'b1000: return PRE_W'(8191);
      default: return PRE_W'(127);
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] loadVal(input logic [1:0] sel);
    case (sel)
      2'b00:   return CNT_W'(1023);
      2'b01:   return CNT_W'(4095);
      2'b10:   return CNT_W'(8191);
      default: return CNT_W'(16383);
    endcase
  endfunction

endpackage

// File: rtl/wdw_datapath.sv
module wdw_datapath
  import wdw_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int PW = PRE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  cfg_t          cfg,
  input  strobe_t       strobe,
  output logic [CW-1:0] cnt,
  output logic          running,
  output logic          ufEvent
);

  logic [PW-1:0] pre;
  logic [PW-1:0] preLast;
  logic          tick;

  assign preLast = divLast(cfg.divSel);
  assign tick    = running && (pre == preLast);
  // a refresh in the same cycle wins over the underflow
  assign ufEvent = tick && (cnt == '0) && !strobe.loadCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pre     <= '0;
      cnt     <= '0;
      running <= 1'b0;
    end else if (strobe.loadCnt) begin
      pre     <= '0;
      cnt     <= loadVal(cfg.perSel);
      running <= 1'b1;
    end else if (running) begin
      if (tick) begin
        pre <= '0;
        if (cnt == '0) running <= 1'b0;
        else           cnt     <= cnt - 1'b1;
      end else begin
        pre <= pre + 1'b1;
      end
    end
  end

  p_load_value_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadCnt |=> running && (cnt == loadVal($past(cfg.perSel))));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (tick && (cnt != '0) && !strobe.loadCnt) |=> (cnt == $past(cnt) - 1'b1));

  p_hold_between_ticks_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!tick && !strobe.loadCnt) |=> $stable(cnt));

  p_stop_r9: assert property (@(posedge clk) disable iff (!rstN)
    ufEvent |=> (!running && (cnt == '0)));

  p_div_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    running |-> legalDiv(cfg.divSel));

endmodule

// File: rtl/wdw_ctrl.sv
module wdw_ctrl
  import wdw_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = WORD_W,
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          autoStart,
  input  logic [DW-1:0] autoCfg,
  input  logic [CW-1:0] cnt,
  input  logic          running,
  input  logic          ufEvent,
  output cfg_t          cfg,
  output strobe_t       strobe,
  output logic          errOut
);

  localparam logic [AW-1:0] ADDR_CFG = AW'(0);
  localparam logic [AW-1:0] ADDR_REF = AW'(1);
  localparam logic [AW-1:0] ADDR_CNT = AW'(2);
  localparam logic [7:0]    KEY_ARM  = 8'h00;
  localparam logic [7:0]    KEY_FIRE = 8'hFF;

  logic [DW-1:0] ctrlReg;
  logic [DW-1:0] effWord;
  logic          locked;
  logic          armed;
  logic          ufFlag;
  logic          refErrFlag;
  logic          cfgWrite;
  logic          refWrite;
  logic          fire;
  logic          refErr;

  logic [CW-1:0] loadV, thrQ1, thrQ2, thrQ3, startThr, endThr;
  logic          endOpen;
  logic          inWindow;

  // configuration source
  assign effWord = autoStart ? (autoCfg & CFG_MASK) : ctrlReg;
  assign cfg     = toCfg(effWord);

  // write decode
  assign cfgWrite = wrEn && (wrAddr == ADDR_CFG) && !locked && legalDiv(wrData[7:4]);
  assign refWrite = wrEn && (wrAddr == ADDR_REF);
  assign fire     = refWrite && armed && (wrData[7:0] == KEY_FIRE);

  // window thresholds from the selected load value
  assign loadV = loadVal(cfg.perSel);
  assign thrQ1 = loadV >> 2;
  assign thrQ2 = loadV >> 1;
  assign thrQ3 = (loadV >> 1) + (loadV >> 2) + 1'b1;

  always_comb begin
    case (cfg.startSel)
      2'b00:   startThr = thrQ1;
      2'b01:   startThr = thrQ2;
      2'b10:   startThr = thrQ3;
      default: startThr = loadV;
    endcase
    endOpen = 1'b0;
    case (cfg.endSel)
      2'b00:   endThr = thrQ3;
      2'b01:   endThr = thrQ2;
      2'b10:   endThr = thrQ1;
      default: begin endThr = '0; endOpen = 1'b1; end
    endcase
  end

  assign inWindow = (cnt <= startThr) && (endOpen || (cnt > endThr));

  assign strobe.loadCnt = fire && (!running || inWindow);
  assign strobe.armSeq  = refWrite && (wrData[7:0] == KEY_ARM);
  assign refErr         = fire && running && !inWindow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg    <= CFG_RESET;
      locked     <= 1'b0;
      armed      <= 1'b0;
      ufFlag     <= 1'b0;
      refErrFlag <= 1'b0;
      errOut     <= 1'b0;
    end else begin
      if (cfgWrite) ctrlReg <= wrData & CFG_MASK;
      if (cfgWrite || strobe.loadCnt) locked <= 1'b1;
      if (refWrite) armed <= strobe.armSeq;
      if (ufEvent) ufFlag <= 1'b1;
      if (refErr) refErrFlag <= 1'b1;
      errOut <= ufEvent || refErr;
    end
  end

  // read port
  always_comb begin
    case (rdAddr)
      ADDR_CFG: rdData = effWord;
      ADDR_REF: rdData = DW'({running, refErrFlag, ufFlag});
      ADDR_CNT: rdData = DW'(cnt);
      default:  rdData = '0;
    endcase
  end

  p_cfg_frozen_r5: assert property (@(posedge clk) disable iff (!rstN)
    locked |=> $stable(ctrlReg));

  p_rsvd_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlReg & ~CFG_MASK) == '0);

  p_referr_r8: assert property (@(posedge clk) disable iff (!rstN)
    refErr |=> (errOut && refErrFlag));

  p_uf_flag_r9: assert property (@(posedge clk) disable iff (!rstN)
    ufEvent |=> (errOut && ufFlag));

  p_err_cause_r9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(errOut) |-> ($rose(ufFlag) || $rose(refErrFlag) || $past(ufEvent) || $past(refErr)));

endmodule

// File: rtl/wdog_window.sv
module wdog_window
  import wdw_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = WORD_W,
  parameter int CW     = CNT_W,
  parameter int PW     = PRE_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [DATA_W-1:0] rdData,
  input  logic              autoStart,
  input  logic [DATA_W-1:0] autoCfg,
  output logic              errOut
);

  cfg_t          cfg;
  strobe_t       strobe;
  logic [CW-1:0] cnt;
  logic          running;
  logic          ufEvent;

  wdw_ctrl #(.AW(ADDR_W), .DW(DATA_W), .CW(CW)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .rdAddr    (rdAddr),
    .rdData    (rdData),
    .autoStart (autoStart),
    .autoCfg   (autoCfg),
    .cnt       (cnt),
    .running   (running),
    .ufEvent   (ufEvent),
    .cfg       (cfg),
    .strobe    (strobe),
    .errOut    (errOut)
  );

  wdw_datapath #(.CW(CW), .PW(PW)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .cfg     (cfg),
    .strobe  (strobe),
    .cnt     (cnt),
    .running (running),
    .ufEvent (ufEvent)
  );

endmodule

// File: tb/wdog_window_test.sv
`timescale 1ns/100ps
module wdog_window_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic [1:0]  wrAddr = '0;
  logic [15:0] wrData = '0;
  logic [1:0]  rdAddr = '0;
  logic [15:0] rdData;
  logic        autoStart = 1'b0;
  logic [15:0] autoCfg = '0;
  logic        errOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wdog_window uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .autoStart(autoStart), .autoCfg(autoCfg),
    .errOut(errOut)
  );

  // {write word, expected readback, expected timeout cycles (0 = not measured)}
  localparam logic [51:0] VECS [7] = '{
    {16'hFFFF, 16'h33F3, 20'd0},      // R2 reserved bits dropped
    {16'h0020, 16'h33F3, 20'd0},      // R3 code 0010 prohibited
    {16'h0090, 16'h33F3, 20'd0},      // R3 code 1001 prohibited
    {16'h3310, 16'h3310, 20'd4096},   // R4 div 4, load 1023
    {16'h3311, 16'h3311, 20'd16384},  // R4 div 4, load 4095
    {16'h3340, 16'h3340, 20'd65536},  // R4 div 64, load 1023
    {16'h0C70, 16'h0070, 20'd0}       // R2 bits 11:10 dropped
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    wrEn = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    rdAddr = a;
    #0.5;
    v = rdData;
  endtask

  task automatic refresh();
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h00FF);
  endtask

  task automatic refreshAt(input logic [15:0] target);
    wr(2'd1, 16'h0000);
    rdAddr = 2'd2;
    for (int i = 0; i < 20000; i++) begin
      #0.5;
      if (rdData == target) break;
      @(negedge clk);
    end
    wr(2'd1, 16'h00FF);
  endtask

  task automatic measure(output int j);
    j = 0;
    while (!errOut && j < 140000) begin
      @(negedge clk);
      j++;
    end
  endtask

  initial begin
    logic [15:0] v;
    int          j;

    // R1 reset state
    doReset();
    rd(2'd0, v); chk("R1 cfg reset", v, 16'h33F3);
    rd(2'd1, v); chk("R1 status reset", v, 16'h0000);
    rd(2'd2, v); chk("R1 count reset", v, 16'h0000);
    chk("R1 errOut reset", errOut, 1'b0);

    // vector table: R2 R3 R4
    for (int k = 0; k < 7; k++) begin
      doReset();
      wr(2'd0, VECS[k][51:36]);
      rd(2'd0, v);
      chk($sformatf("R2/R3 readback vec %0d", k), v, VECS[k][35:20]);
      if (VECS[k][19:0] != 0) begin
        refresh();
        measure(j);
        chk($sformatf("R4 timeout vec %0d", k), j, VECS[k][19:0]);
      end
    end

    // R3 prohibited write does not lock; R5 single write
    doReset();
    wr(2'd0, 16'h0020);
    wr(2'd0, 16'h3310);
    rd(2'd0, v); chk("R3 write after prohibited", v, 16'h3310);
    wr(2'd0, 16'h3311);
    rd(2'd0, v); chk("R5 second write ignored", v, 16'h3310);

    // R6 refresh sequence
    wr(2'd1, 16'h00FF);
    rd(2'd1, v); chk("R6 lone FF no start", v, 16'h0000);
    wr(2'd1, 16'h0000);
    wr(2'd1, 16'h0055);
    wr(2'd1, 16'h00FF);
    rd(2'd1, v); chk("R6 broken sequence no start", v, 16'h0000);
    refresh();
    rd(2'd1, v); chk("R6 start running", v, 16'h0004);
    rd(2'd2, v); chk("R6 start load value", v, 16'd1023);

    // R9 underflow, stop, restart
    measure(j);
    chk("R9 underflow timing", j, 4096);
    rd(2'd1, v); chk("R9 uf flag, stopped", v, 16'h0001);
    @(negedge clk);
    chk("R9 errOut one cycle", errOut, 1'b0);
    repeat (20) @(negedge clk);
    rd(2'd2, v); chk("R9 count held at 0", v, 16'h0000);
    rd(2'd1, v); chk("R9 still stopped", v, 16'h0001);
    refresh();
    rd(2'd1, v); chk("R9 restart running", v, 16'h0005);
    rd(2'd2, v); chk("R9 restart load", v, 16'd1023);

    // R5 lock once counter started
    doReset();
    refresh();
    wr(2'd0, 16'h3310);
    rd(2'd0, v); chk("R5 write after start ignored", v, 16'h33F3);

    // R7 R8 window: start 50% (thr 511), end 25% (thr 255)
    doReset();
    wr(2'd0, 16'h1210);
    refresh();
    refresh();
    chk("R8 early refresh errOut", errOut, 1'b1);
    rd(2'd1, v); chk("R8 early refresh flag", v, 16'h0006);
    @(negedge clk);
    chk("R8 errOut one cycle", errOut, 1'b0);
    refreshAt(16'd512);
    chk("R8 reject at 512", errOut, 1'b1);
    rd(2'd2, v); chk("R8 no reload at 512", (v <= 16'd512), 1'b1);
    refreshAt(16'd511);
    chk("R7 accept at 511 no error", errOut, 1'b0);
    rd(2'd2, v); chk("R7 reload at 511", v, 16'd1023);
    refreshAt(16'd256);
    chk("R7 accept at 256 no error", errOut, 1'b0);
    rd(2'd2, v); chk("R7 reload at 256", v, 16'd1023);
    refreshAt(16'd255);
    chk("R8 reject at 255", errOut, 1'b1);
    rd(2'd2, v); chk("R8 no reload at 255", (v <= 16'd255), 1'b1);

    // R7 full window: refresh at load value and at zero
    doReset();
    wr(2'd0, 16'h3310);
    refresh();
    refresh();
    chk("R7 full window accept at top", errOut, 1'b0);
    refreshAt(16'd0);
    chk("R7 full window accept at 0", errOut, 1'b0);
    rd(2'd2, v); chk("R7 reload from 0", v, 16'd1023);
    rd(2'd1, v); chk("R7 no flags in full window", v, 16'h0004);

    // R10 auto-start configuration
    autoStart = 1'b1;
    autoCfg   = 16'hCC10;
    doReset();
    rd(2'd0, v); chk("R10 auto cfg readback", v, 16'h0010);
    refresh();
    measure(j);
    chk("R10 auto cfg timeout", j, 4096);
    autoStart = 1'b0;

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule